// File: doc/BRIEF.md
# Direct-Connect Interrupt Line Router

This block drives a small, parameterised set of dedicated interrupt lines. Each line can be tied to any one GPIO pin so that the pin's event reaches the interrupt controller directly, without passing through the shared summary interrupt. Software binds a line by writing that line's configuration word over a simple register bus. The word holds a target code, the index of the source pin and the polarity of the source.

The block receives the already-synchronised pin levels and, for each pin, a direct-connect enable bit. The enable comes from that pin's own routing register, which lives elsewhere. The downstream controller accepts only active-high requests, so a source marked active-low is inverted here. Every line output is therefore active-high. The outputs are registered. To bind a pin cleanly, software first clears the pin's summary-path raw-status enable and interrupt enable. It then sets the pin's direct-connect enable, with "no target" code 7 in that pin's routing register. Finally it writes the line word here.

Top module: `dcr_router`

## Requirements
- R1: While reset is held and on the first cycle after it, every line output is 0 and every line configuration word reads back as 0.
- R2: The word for line n is at byte address 0x700 + 4*n for n below the line count. A write to any other address changes no line's word, and a read of any other address returns 0.
- R3: A line word keeps bits 11:0 of the written data: target code in bits 2:0, pin index in bits 10:3, polarity in bit 11. Bits 31:12 are discarded and read back as 0.
- R4: A line output can be 1 only when its target code equals 4 (main processor). Every other code holds the line at 0.
- R5: A line output can be 1 only when the direct-connect enable bit of the selected pin is 1.
- R6: With polarity bit 11 set, the line follows the selected pin level. With bit 11 clear, the line follows the inverted pin level.
- R7: A pin index equal to or above the pin count holds the line at 0, whatever the polarity.
- R8: The line output is registered. A pin or enable change shows on the output one clock edge later. A configuration write takes effect on the output one edge after the edge that stores it.
- R9: Lines are independent. Several lines may select the same pin, each with its own polarity and target code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Synchronised pin levels |
| pin_dc_en | input | NUM_PINS | Per-pin direct-connect enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| line_irq | output | NUM_LINES | Active-high direct interrupt lines |

## Verification
A corrupted stored word shows up at the register port on the next read. At the line outputs it shows up one edge after the pin it should have selected moves: the line follows the wrong pin, ignores its enable or fires with the wrong sense. The bench therefore drives every pin other than the selected one, and its enable, to the opposite value. A wrong mux index then flips the output at once. A flop that is missing or added in the output path moves the first observed change by one edge, and the latency checks sample both sides of that edge.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CFG_W     = 12;
  localparam int unsigned PIN_IDX_W = 8;
  localparam logic [ADDR_W-1:0] LINE_BASE = 12'h700;
  localparam logic [2:0]        TGT_MAIN  = 3'd4;

  // bit 11 polarity, bits 10:3 pin index, bits 2:0 target code
  typedef struct packed {
    logic                 pol_hi;
    logic [PIN_IDX_W-1:0] pin;
    logic [2:0]           tgt;
  } line_cfg_t;

  function automatic logic [ADDR_W-1:0] addr_to_line(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - LINE_BASE;
    return off >> 2;
  endfunction

  function automatic logic addr_hits(input logic [ADDR_W-1:0] a, input int unsigned n_lines);
    logic [ADDR_W-1:0] idx;
    idx = addr_to_line(a);
    return (a >= LINE_BASE) && (a[1:0] == 2'b00) && (32'(idx) < n_lines);
  endfunction

  function automatic logic apply_pol(input logic lvl, input logic pol_hi);
    return pol_hi ? lvl : ~lvl;
  endfunction

  function automatic logic line_fires(input logic tgt_ok, input logic in_rng,
                                      input logic dc, input logic adj);
    return tgt_ok & in_rng & dc & adj;
  endfunction
endpackage

// File: rtl/dcr_cfg_regs.sv
module dcr_cfg_regs
  import dcr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [DATA_W-1:0]               reg_rdata,
  output line_cfg_t [NUM_LINES-1:0]       cfg_o
);
  logic              addr_hit;
  logic [ADDR_W-1:0] addr_line;
  logic              unused_wdata_hi;
  line_cfg_t [NUM_LINES-1:0] cfg_q;

  assign addr_hit        = addr_hits(reg_addr, NUM_LINES);
  assign addr_line       = addr_to_line(reg_addr);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CFG_W];

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_word
    logic wr_sel;
    assign wr_sel = reg_we && addr_hit && (addr_line == ADDR_W'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[n] <= '0;
      else if (wr_sel) cfg_q[n] <= line_cfg_t'(reg_wdata[CFG_W-1:0]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (addr_hit && (addr_line == ADDR_W'(n)))
        reg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q[n]};
    end
  end

  assign cfg_o = cfg_q;

  // R2: a write that misses every line word leaves all words untouched
  a_r2_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !addr_hit) |=> $stable(cfg_q));

  // R3: reserved upper read bits stay zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:CFG_W] == '0);
endmodule

// File: rtl/dcr_line_sel.sv
module dcr_line_sel
  import dcr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  line_cfg_t             cfg_i,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [NUM_PINS-1:0]   pin_dc_en,
  output logic                  tgt_ok_o,
  output logic                  in_rng_o,
  output logic                  dc_o,
  output logic                  lvl_o,
  output logic                  drive_o
);
  logic adj;

  assign tgt_ok_o = (cfg_i.tgt == TGT_MAIN);
  assign in_rng_o = (32'(cfg_i.pin) < NUM_PINS);

  // explicit compare mux: an index past the last pin selects nothing
  always_comb begin
    lvl_o = 1'b0;
    dc_o  = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (cfg_i.pin == PIN_IDX_W'(p)) begin
        lvl_o = pin_in[p];
        dc_o  = pin_dc_en[p];
      end
    end
  end

  assign adj     = apply_pol(lvl_o, cfg_i.pol_hi);
  assign drive_o = line_fires(tgt_ok_o, in_rng_o, dc_o, adj);
endmodule

// File: rtl/dcr_router.sv
module dcr_router
  import dcr_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS-1:0]    pin_in,
  input  logic [NUM_PINS-1:0]    pin_dc_en,
  input  logic                   reg_we,
  input  logic [11:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [NUM_LINES-1:0]   line_irq
);
  line_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0] tgt_ok, in_rng, sel_dc, sel_lvl, drive;

  dcr_cfg_regs #(.NUM_LINES(NUM_LINES)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_o(cfg)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    dcr_line_sel #(.NUM_PINS(NUM_PINS)) sel_i (
      .cfg_i(cfg[n]), .pin_in(pin_in), .pin_dc_en(pin_dc_en),
      .tgt_ok_o(tgt_ok[n]), .in_rng_o(in_rng[n]), .dc_o(sel_dc[n]),
      .lvl_o(sel_lvl[n]), .drive_o(drive[n])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_irq[n] <= 1'b0;
      else        line_irq[n] <= drive[n];
    end

    // R4: only the main-processor target code lets a line fire
    a_r4_target_gate: assert property (@(posedge clk) disable iff (!rst_n)
      line_irq[n] |-> $past(cfg[n].tgt) == TGT_MAIN);
    // R5: the selected pin's direct-connect enable was set
    a_r5_dc_enable: assert property (@(posedge clk) disable iff (!rst_n)
      line_irq[n] |-> $past(sel_dc[n]));
    // R7: the pin index was in range
    a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      line_irq[n] |-> $past(in_rng[n]));
    // R6: polarity-adjusted level was high
    a_r6_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      line_irq[n] |-> $past(sel_lvl[n] == cfg[n].pol_hi));
  end

  // R1: reset holds every line low
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> line_irq == '0);
endmodule

// File: tb/dcr_router_tb_top.sv
`timescale 1ns/1ps
module dcr_router_tb_top;
  localparam int NP = 16;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0, pin_dc_en = '0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] line_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dcr_router #(.NUM_PINS(NP), .NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dc_en(pin_dc_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .line_irq(line_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [11:0] word(input int tgt, input int idx, input int pol);
    return 12'(tgt % 8 + (idx % 256) * 8 + (pol % 2) * 2048);
  endfunction

  // expected line value computed from field arithmetic
  function automatic logic exp_line(input logic [11:0] w, input logic [NP-1:0] p,
                                    input logic [NP-1:0] e);
    int tgt, idx, pol;
    tgt = int'(w) % 8;
    idx = (int'(w) / 8) % 256;
    pol = (int'(w) / 2048) % 2;
    if (tgt != 4 || idx >= NP) return 1'b0;
    if (!e[idx]) return 1'b0;
    return (pol == 1) ? p[idx] : !p[idx];
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] w;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq in reset", 32'(line_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(line_irq), 0);
    for (int n = 0; n < NL; n++) begin
      rd(12'h700 + 12'(4 * n), d);
      chk("R1 word after reset", d, 0);
    end

    // R3: only low 12 bits stored
    wr(12'h704, 32'hFFFF_F123);
    rd(12'h704, d);
    chk("R3 readback masked", d, 32'h123);

    // R2: stray addresses
    wr(12'h6FC, 32'h0000_0ABC);
    wr(12'h702, 32'h0000_0ABC);
    wr(12'h700 + 12'(4 * NL), 32'h0000_0ABC);
    wr(12'h000, 32'h0000_0ABC);
    for (int n = 0; n < NL; n++) begin
      rd(12'h700 + 12'(4 * n), d);
      chk("R2 word untouched", d, (n == 1) ? 32'h123 : 0);
    end
    rd(12'h6FC, d); chk("R2 read stray low", d, 0);
    rd(12'h702, d); chk("R2 read misaligned", d, 0);
    rd(12'h700 + 12'(4 * NL), d); chk("R2 read past last", d, 0);

    // R4 R5 R6: sweep each line over target, polarity, enable, level
    for (int n = 0; n < NL; n++) begin
      int idx;
      idx = n * 3 + 1;
      for (int t = 0; t < 8; t++)
        for (int pol = 0; pol < 2; pol++)
          for (int e = 0; e < 2; e++)
            for (int lv = 0; lv < 2; lv++) begin
              logic [NP-1:0] pv, ev;
              pv = (lv != 0) ? '0 : '1;
              ev = (e != 0) ? '0 : '1;
              pv[idx] = (lv != 0);
              ev[idx] = (e != 0);
              pin_in = pv; pin_dc_en = ev;
              w = word(t, idx, pol);
              wr(12'h700 + 12'(4 * n), 32'(w));
              @(negedge clk);
              chk("R4 R5 R6 sweep", 32'(line_irq[n]), 32'(exp_line(w, pv, ev)));
            end
      wr(12'h700 + 12'(4 * n), 0);
    end

    // R7: out-of-range indices stay low
    pin_dc_en = '1;
    foreach (w[i]) ;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = (k == 0) ? NP : (k == 1) ? 200 : (k == 2) ? 255 : NP - 1;
      for (int pol = 0; pol < 2; pol++) begin
        pin_in = (pol == 1) ? '1 : '0;
        w = word(4, idx, pol);
        wr(12'h700, 32'(w));
        @(negedge clk);
        chk("R7 index range", 32'(line_irq[0]), (idx < NP) ? 1 : 0);
      end
    end

    // R8: pin change latency
    pin_in = '0;
    wr(12'h700, 32'(word(4, 2, 1)));
    @(negedge clk);
    chk("R8 idle", 32'(line_irq[0]), 0);
    pin_in[2] = 1'b1;
    #1 chk("R8 before edge", 32'(line_irq[0]), 0);
    @(negedge clk);
    chk("R8 after one edge", 32'(line_irq[0]), 1);
    // R8: configuration write latency
    wr(12'h700, 32'(word(4, 2, 0)));
    chk("R8 cfg stored edge", 32'(line_irq[0]), 1);
    @(negedge clk);
    chk("R8 cfg next edge", 32'(line_irq[0]), 0);

    // R9: all lines on one pin, mixed polarity and target
    pin_dc_en = '1;
    wr(12'h700, 32'(word(4, 5, 1)));
    wr(12'h704, 32'(word(4, 5, 0)));
    wr(12'h708, 32'(word(7, 5, 1)));
    wr(12'h70C, 32'(word(4, 5, 0)));
    pin_in = '0; pin_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 shared pin high", 32'(line_irq), 32'h1);
    pin_in[5] = 1'b0;
    @(negedge clk);
    chk("R9 shared pin low", 32'(line_irq), 32'hA);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule